// File: doc/BRIEF.md
# Power-On Strap Latch and Boot Decoder

This block samples eight strap pads once after a cold reset and keeps what it saw in an always-on register. The straps are a UART download request, a selector for the internal boot memory type (flash or PSRAM), a test mode request, an OTP autoload bypass request and a 4-bit test configuration code. Three of them are active low and are stored in positive logic. The block drives the strap pull-ups while the pads settle. It then captures the synchronised pad levels in a single-cycle strobe and raises a valid flag.

From the stored values it decodes the boot branch, the OTP bypass control, the test configuration presented to the test logic, and a hold on the low-power processor. A programmed OTP bit can block UART download permanently. Warm resets do not reload the straps: watchdog, system, brown-out and deep-sleep wake resets leave the stored values and the valid flag as they are. The combined status byte can be read through a one-word synchronous read port.

Top module: `strap_boot_latch`

## Requirements
- R1: `padUartDlN`, `padTestN` and `padOtpBypN` are active low and are stored inverted. `padMemSel` and `padTestCfg` are stored exactly as sampled.
- R2: The status word has the following fields, where a stored 1 means the request is active:
  - bit 16: OTP bypass
  - bit 17: test mode
  - bit 18: memory type (0 = PSRAM, 1 = flash)
  - bit 19: UART download
  - bits 23:20: test configuration code

  Every other bit reads 0.
- R3: Only a cold reset causes a new sample. A cold reset is `chipEnRstN` or `porRstN` going low. Pulsing `warmRstN` keeps the stored status and `latchValid`, and clears only `rdData` to 0.
- R4: `pullUpEn` has bit 0 for UART download, bit 1 for test mode and bit 2 for OTP bypass. It reads 3'b111 from cold reset until the capture, and 3'b000 once `latchValid` is high.
- R5: With the default settle count of 8, the straps are captured on the 9th rising clock edge after cold reset release. `latchValid` rises on that same edge and then stays high until the next cold reset.
- R6: `bootBranch` uses the encoding 0 = normal, 1 = UART download, 2 = test. Test mode has priority over UART download, and UART download has priority over normal. Before `latchValid` the branch reads 0.
- R7: While `otpUartDlDis` is 1, `bootBranch` never reads 1. Status bit 19 still shows the sampled request.
- R8: `otpBypass` and `testCfg` follow the stored values only while the stored test mode is active. Otherwise they read 0, whatever the stored bypass and configuration values are.
- R9: `lpBootHold` is 1 exactly when the decoded branch is test mode.
- R10: `memSelOe` is always 0, so the memory select pad is never driven.
- R11: When `rdEn` is high at a rising edge, `rdData` takes the status word at that edge. Otherwise `rdData` keeps its value.
- R12: Pad changes after the capture do not affect the status word or any decoded output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| chipEnRstN | input | 1 | Chip-enable reset, active low (cold) |
| porRstN | input | 1 | Power-on reset, active low (cold) |
| warmRstN | input | 1 | Combined warm resets, active low |
| padUartDlN | input | 1 | UART download strap, low requests download |
| padMemSel | input | 1 | Internal memory select strap, 1 = flash |
| padTestN | input | 1 | Test mode strap, low requests test mode |
| padOtpBypN | input | 1 | OTP bypass strap, low requests bypass |
| padTestCfg | input | 4 | Test configuration strap code |
| otpUartDlDis | input | 1 | OTP bit that blocks UART download |
| rdEn | input | 1 | Status read strobe |
| pullUpEn | output | 3 | Pull-up enables {OTP bypass, test, UART download} |
| memSelOe | output | 1 | Memory select pad output enable, always 0 |
| latchValid | output | 1 | Straps have been captured |
| rdData | output | 32 | Registered status word |
| bootBranch | output | 2 | Decoded boot branch |
| otpBypass | output | 1 | Bypass the OTP autoload |
| testCfg | output | 4 | Test configuration code for the test logic |
| lpBootHold | output | 1 | Hold the low-power processor out of boot |

## Verification
The assertions check the following on every cycle:
- The stored status word stays stable once it is valid, which covers warm resets and late pad changes.
- The valid flag never drops.
- The pull-ups track the valid flag.
- The branch reads normal before capture.
- The OTP disable blocks the UART branch.
- The bypass and the processor hold appear only in test mode.
- Reads return the status word one edge later.

Only the bench scenarios can show the other behaviours:
- the exact capture edge;
- the per-strap polarity and field positions;
- the priority of test mode over a simultaneous UART request;
- that a warm reset clears only the read register and leaves the captured value in place.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int STATUS_W   = 32;
  localparam int CFG_W      = 4;
  localparam int BIT_OTPBYP = 16;
  localparam int BIT_TEST   = 17;
  localparam int BIT_MEM    = 18;
  localparam int BIT_UDL    = 19;
  localparam int CFG_LSB    = 20;
  localparam int PAD_W      = 4 + CFG_W;
  localparam int PULL_W     = 3;

  typedef enum logic [1:0] {
    BOOT_NORMAL = 2'd0,
    BOOT_UART   = 2'd1,
    BOOT_TEST   = 2'd2
  } bootBranchT;

  typedef struct packed {
    logic capture;
    logic valid;
    logic pullOn;
  } strapCtrlT;

  typedef struct packed {
    logic             udlReq;
    logic             memFlash;
    logic             testMode;
    logic             otpByp;
    logic [CFG_W-1:0] cfg;
  } strapStoreT;
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= '0;
        else       stageQ[g] <= dIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[g] <= '0;
        else       stageQ[g] <= stageQ[g-1];
      end
    end
  end

  assign dOut = stageQ[STAGES-1];
endmodule

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic      clk,
  input  logic      coldRstN,
  output strapCtrlT ctrl
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  typedef enum logic [1:0] {ST_SETTLE, ST_CAPTURE, ST_DONE} stateT;

  stateT            state;
  logic [CNT_W-1:0] settleCnt;

  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN) begin
      state     <= ST_SETTLE;
      settleCnt <= '0;
    end else begin
      unique case (state)
        ST_SETTLE: begin
          if (settleCnt == CNT_LAST) state <= ST_CAPTURE;
          else                       settleCnt <= settleCnt + 1'b1;
        end
        ST_CAPTURE: state <= ST_DONE;
        default:    state <= ST_DONE;
      endcase
    end
  end

  always_comb begin
    ctrl.capture = (state == ST_CAPTURE);
    ctrl.valid   = (state == ST_DONE);
    ctrl.pullOn  = (state != ST_DONE);
  end
endmodule

// File: rtl/strap_datapath.sv
module strap_datapath
  import strap_pkg::*;
(
  input  logic                clk,
  input  logic                coldRstN,
  input  logic                warmRstN,
  input  strapCtrlT           ctrl,
  input  logic [PAD_W-1:0]    padSync,
  input  logic                otpUartDlDis,
  input  logic                rdEn,
  output logic [STATUS_W-1:0] statusWord,
  output logic [STATUS_W-1:0] rdData,
  output logic [1:0]          bootBranch,
  output logic                otpBypass,
  output logic [CFG_W-1:0]    testCfg,
  output logic                lpBootHold
);
  strapStoreT store;
  strapStoreT sampled;
  logic       rdRstN;
  logic       testActive;
  logic       uartActive;
  bootBranchT branch;

  // padSync order: {udlN, memSel, testN, otpBypN, cfg}
  always_comb begin
    sampled.udlReq   = ~padSync[PAD_W-1];
    sampled.memFlash =  padSync[PAD_W-2];
    sampled.testMode = ~padSync[PAD_W-3];
    sampled.otpByp   = ~padSync[PAD_W-4];
    sampled.cfg      =  padSync[CFG_W-1:0];
  end

  // Always-on store: only a cold reset clears it; only the capture strobe loads it.
  always_ff @(posedge clk or negedge coldRstN) begin
    if (!coldRstN)        store <= '0;
    else if (ctrl.capture) store <= sampled;
  end

  always_comb begin
    statusWord                     = '0;
    statusWord[BIT_OTPBYP]         = store.otpByp;
    statusWord[BIT_TEST]           = store.testMode;
    statusWord[BIT_MEM]            = store.memFlash;
    statusWord[BIT_UDL]            = store.udlReq;
    statusWord[CFG_LSB +: CFG_W]   = store.cfg;
  end

  always_comb begin
    testActive = ctrl.valid & store.testMode;
    uartActive = ctrl.valid & store.udlReq & ~otpUartDlDis;
    if (testActive)      branch = BOOT_TEST;
    else if (uartActive) branch = BOOT_UART;
    else                 branch = BOOT_NORMAL;
    bootBranch = branch;
    otpBypass  = testActive & store.otpByp;
    testCfg    = testActive ? store.cfg : '0;
    lpBootHold = testActive;
  end

  assign rdRstN = coldRstN & warmRstN;

  always_ff @(posedge clk or negedge rdRstN) begin
    if (!rdRstN)   rdData <= '0;
    else if (rdEn) rdData <= statusWord;
  end
endmodule

// File: rtl/strap_boot_latch.sv
module strap_boot_latch
  import strap_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic        clk,
  input  logic        chipEnRstN,
  input  logic        porRstN,
  input  logic        warmRstN,
  input  logic        padUartDlN,
  input  logic        padMemSel,
  input  logic        padTestN,
  input  logic        padOtpBypN,
  input  logic [3:0]  padTestCfg,
  input  logic        otpUartDlDis,
  input  logic        rdEn,
  output logic [2:0]  pullUpEn,
  output logic        memSelOe,
  output logic        latchValid,
  output logic [31:0] rdData,
  output logic [1:0]  bootBranch,
  output logic        otpBypass,
  output logic [3:0]  testCfg,
  output logic        lpBootHold
);
  logic                coldRstN;
  strapCtrlT           ctrl;
  logic [PAD_W-1:0]    padSync;
  logic [STATUS_W-1:0] statusWord;

  assign coldRstN = chipEnRstN & porRstN;

  strap_sync #(.WIDTH(PAD_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (coldRstN),
    .dIn  ({padUartDlN, padMemSel, padTestN, padOtpBypN, padTestCfg}),
    .dOut (padSync)
  );

  strap_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk      (clk),
    .coldRstN (coldRstN),
    .ctrl     (ctrl)
  );

  strap_datapath u_dp (
    .clk          (clk),
    .coldRstN     (coldRstN),
    .warmRstN     (warmRstN),
    .ctrl         (ctrl),
    .padSync      (padSync),
    .otpUartDlDis (otpUartDlDis),
    .rdEn         (rdEn),
    .statusWord   (statusWord),
    .rdData       (rdData),
    .bootBranch   (bootBranch),
    .otpBypass    (otpBypass),
    .testCfg      (testCfg),
    .lpBootHold   (lpBootHold)
  );

  assign pullUpEn   = {PULL_W{ctrl.pullOn}};
  assign memSelOe   = 1'b0;
  assign latchValid = ctrl.valid;
endmodule

// File: rtl/strap_boot_latch_chk.sv
module strap_boot_latch_chk (
  input logic        clk,
  input logic        coldRstN,
  input logic        warmRstN,
  input logic        latchValid,
  input logic [2:0]  pullUpEn,
  input logic [1:0]  bootBranch,
  input logic        otpBypass,
  input logic [3:0]  testCfg,
  input logic        lpBootHold,
  input logic        otpUartDlDis,
  input logic        rdEn,
  input logic [31:0] rdData,
  input logic [31:0] statusWord
);
  AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!coldRstN)
    (latchValid && $past(latchValid)) |-> $stable(statusWord)); // R3

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!coldRstN)
    latchValid |=> latchValid); // R5

  AST_PULL_BEFORE: assert property (@(posedge clk) disable iff (!coldRstN)
    !latchValid |-> (pullUpEn == 3'b111)); // R4

  AST_PULL_AFTER: assert property (@(posedge clk) disable iff (!coldRstN)
    latchValid |-> (pullUpEn == 3'b000)); // R4

  AST_PRE_VALID_NORMAL: assert property (@(posedge clk) disable iff (!coldRstN)
    !latchValid |-> (bootBranch == 2'd0 && !otpBypass && testCfg == 4'd0)); // R6

  AST_OTP_BLOCKS_UART: assert property (@(posedge clk) disable iff (!coldRstN)
    otpUartDlDis |-> (bootBranch != 2'd1)); // R7

  AST_BYPASS_TEST_ONLY: assert property (@(posedge clk) disable iff (!coldRstN)
    (otpBypass || testCfg != 4'd0) |-> (bootBranch == 2'd2)); // R8

  AST_HOLD_IN_TEST: assert property (@(posedge clk) disable iff (!coldRstN)
    lpBootHold == (bootBranch == 2'd2)); // R9

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!coldRstN || !warmRstN)
    rdEn |=> (rdData == $past(statusWord))); // R11
endmodule

bind strap_boot_latch strap_boot_latch_chk u_chk (.*);

// File: tb/tb_strap_boot_latch.sv
module tb_strap_boot_latch;
  logic        clk = 1'b0;
  logic        chipEnRstN = 1'b0, porRstN = 1'b0, warmRstN = 1'b1;
  logic        padUartDlN = 1'b1, padMemSel = 1'b0, padTestN = 1'b1, padOtpBypN = 1'b1;
  logic [3:0]  padTestCfg = 4'd0;
  logic        otpUartDlDis = 1'b0, rdEn = 1'b0;
  logic [2:0]  pullUpEn;
  logic        memSelOe, latchValid, otpBypass, lpBootHold;
  logic [31:0] rdData;
  logic [1:0]  bootBranch;
  logic [3:0]  testCfg;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } rdItemT;
  rdItemT rdQ[$];
  logic   rdSeen = 1'b0;

  strap_boot_latch dut (.*);

  always #10 clk = ~clk; // 50 MHz

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: issue a read and push the expected word.
  task automatic readExpect(input logic [31:0] exp, input string tag);
    rdItemT it;
    it.exp = exp; it.tag = tag;
    rdQ.push_back(it);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: compare read data after the edge that loaded it.
  always @(posedge clk) rdSeen <= rdEn;
  always @(negedge clk) begin
    if (rdSeen) begin
      if (rdQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R11 unexpected read actual=%h expected=none", rdData);
      end else begin
        rdItemT it;
        it = rdQ.pop_front();
        check(it.tag, rdData, it.exp);
      end
    end
  end

  task automatic coldCycle(input bit usePor, input logic udN, input logic mem,
                           input logic tN, input logic oN, input logic [3:0] cfg);
    @(negedge clk);
    if (usePor) porRstN = 1'b0; else chipEnRstN = 1'b0;
    padUartDlN = udN; padMemSel = mem; padTestN = tN; padOtpBypN = oN; padTestCfg = cfg;
    @(negedge clk);
    porRstN = 1'b1; chipEnRstN = 1'b1;
    repeat (8) @(negedge clk);
    check("R5 not valid after 8 edges", {31'd0, latchValid}, 32'd0);
    check("R4 pull-ups on while settling", {29'd0, pullUpEn}, 32'd7);
    @(negedge clk);
    check("R5 valid after 9th edge", {31'd0, latchValid}, 32'd1);
    check("R4 pull-ups off after capture", {29'd0, pullUpEn}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R4 reset pull-ups", {29'd0, pullUpEn}, 32'd7);
    check("R6 reset branch normal", {30'd0, bootBranch}, 32'd0);
    check("R5 reset valid low", {31'd0, latchValid}, 32'd0);
    check("R11 reset rdData", rdData, 32'd0);
    check("R10 memSelOe", {31'd0, memSelOe}, 32'd0);

    // Scenario A: UART request, flash, no test, bypass pad low, cfg A.
    padUartDlN = 1'b0; padMemSel = 1'b1; padTestN = 1'b1; padOtpBypN = 1'b0; padTestCfg = 4'hA;
    @(negedge clk);
    porRstN = 1'b1; chipEnRstN = 1'b1;
    repeat (8) @(negedge clk);
    check("R5 not valid after 8 edges", {31'd0, latchValid}, 32'd0);
    @(negedge clk);
    check("R5 valid after 9th edge", {31'd0, latchValid}, 32'd1);
    readExpect(32'h00AD0000, "R1 R2 status A");
    check("R6 uart branch", {30'd0, bootBranch}, 32'd1);
    check("R8 bypass gated in normal", {31'd0, otpBypass}, 32'd0);
    check("R8 cfg gated in normal", {28'd0, testCfg}, 32'd0);
    check("R9 no hold", {31'd0, lpBootHold}, 32'd0);
    otpUartDlDis = 1'b1;
    @(negedge clk);
    check("R7 otp blocks uart", {30'd0, bootBranch}, 32'd0);
    readExpect(32'h00AD0000, "R7 status keeps request");
    otpUartDlDis = 1'b0;
    padUartDlN = 1'b1; padMemSel = 1'b0; padTestN = 1'b0; padOtpBypN = 1'b1; padTestCfg = 4'h5;
    repeat (4) @(negedge clk);
    readExpect(32'h00AD0000, "R12 late pad change ignored");
    check("R12 branch unchanged", {30'd0, bootBranch}, 32'd1);
    warmRstN = 1'b0;
    @(negedge clk);
    warmRstN = 1'b1;
    @(negedge clk);
    check("R3 warm reset clears rdData", rdData, 32'd0);
    check("R3 warm reset keeps valid", {31'd0, latchValid}, 32'd1);
    readExpect(32'h00AD0000, "R3 warm reset keeps status");

    // Scenario B: test mode with bypass, PSRAM, cfg 3 via power-on reset.
    coldCycle(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h3);
    readExpect(32'h00330000, "R1 R2 status B");
    check("R6 test branch", {30'd0, bootBranch}, 32'd2);
    check("R8 bypass in test", {31'd0, otpBypass}, 32'd1);
    check("R8 cfg in test", {28'd0, testCfg}, 32'd3);
    check("R9 hold in test", {31'd0, lpBootHold}, 32'd1);

    // Scenario C: test and UART together via chip-enable reset.
    coldCycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'h0);
    readExpect(32'h000E0000, "R1 R2 status C");
    check("R6 test over uart", {30'd0, bootBranch}, 32'd2);
    check("R8 no bypass requested", {31'd0, otpBypass}, 32'd0);

    // Scenario D: all normal, cfg ignored.
    coldCycle(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'h5);
    readExpect(32'h00540000, "R2 status D");
    check("R6 normal branch", {30'd0, bootBranch}, 32'd0);
    check("R8 cfg hidden in normal", {28'd0, testCfg}, 32'd0);
    check("R10 memSelOe end", {31'd0, memSelOe}, 32'd0);

    repeat (2) @(negedge clk);
    if (rdQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL R11 pending reads actual=%0d expected=0", rdQ.size());
    end
    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule